// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block collects level-type event conditions from a set of sources into a bank of 8-bit interrupt status registers. Each source has a matching mask bit in a second bank of 8-bit registers, which is laid out the same way as the status bank. A single active-high interrupt line tells software that there is something it has not yet looked at.

A rising edge on a source condition is an event. Each event sets that source's sticky status bit. When the source is unmasked, the event also raises the interrupt line. Software works through a simple register bus with an address, read and write strobes, and byte-wide data. Reading a status register returns its current contents. On the following clock edge, the read clears every bit in that register whose condition is no longer present.

The interrupt line does not follow the status bits directly. It follows a per-source "not yet read" flag. A read therefore drops the line even when a status bit stays set because its condition is still active.

Top module: `irq_status_ctrl`

## Requirements
- R1: The address MSB selects the bank: 0 for status, 1 for mask. The lower address bits hold the register index r. Bit b of register r belongs to source 8*r+b. Bits with no source, and registers with an index past the last one, read as 0.
- R2: After reset, all status bits read 0, all mask bits read 1 and the interrupt output is 0.
- R3: A rising edge of a source condition sets its status bit whether or not the source is masked. The bit is readable from the next cycle.
- R4: An event on an unmasked source drives the interrupt output high in the cycle after the condition is first sampled high.
- R5: An event on a masked source leaves the interrupt output unchanged.
- R6: A set status bit stays set after its condition falls, until its register is read.
- R7: A status read returns the value from before the clear. The clear takes effect on the next clock edge, for bits whose condition is low during the read.
- R8: A read of a register while a condition is still high leaves that status bit set. The read still marks the bit as read, so the interrupt output can drop.
- R9: The interrupt output stays high until every unmasked source with an unread event has had its register read.
- R10: A rising edge in the same cycle as a read of its register wins. The status bit stays set and the event counts as unread.
- R11: Clearing a mask bit while its source has an unread event raises the interrupt output on the next cycle. Setting the mask bit again lowers the output.
- R12: Writes to the status bank have no effect.
- R13: A mask register reads back the last value written to it, restricted to bits that have a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_i | input | NUM_SRC | Level condition from each source |
| addr_i | input | IDX_W+1 | Register address: bank bit, then index |
| rd_i | input | 1 | Read strobe; clears on the next edge |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt output, active high |

## Verification
The hardest case to reach is a rising edge arriving in the same cycle as a read of its own register. Random traffic rarely lines these two up, so a directed step holds the condition low, then raises it in exactly the cycle that reads its register. Random condition toggles mixed with random mask writes and status reads then cover the split between unread flags and sticky bits. This includes the cases of reading while the condition is still high and unmasking a source whose event is still unread. A bench reference model predicts every read value and the interrupt line in every cycle.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
   localparam int unsigned REG_W = 8;

   typedef enum logic {
      BANK_STATUS = 1'b0,
      BANK_MASK   = 1'b1
   } bank_e;

   function automatic int unsigned regs_for(int unsigned n_src);
      return (n_src + REG_W - 1) / REG_W;
   endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
   parameter bit IN_SYNC = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond_i,
   input  logic rd_hit_i,
   output logic status_o,
   output logic unread_o
);
   logic cond_s;
   logic cond_q;
   logic rise;
   logic status_q;
   logic unread_q;

   generate
      if (IN_SYNC) begin : g_sync
         logic sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 1'b0;
            else        sync_q <= cond_i;
         end
         assign cond_s = sync_q;
      end else begin : g_direct
         assign cond_s = cond_i;
      end
   endgenerate

   assign rise = cond_s & ~cond_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond_q   <= 1'b0;
         status_q <= 1'b0;
         unread_q <= 1'b0;
      end else begin
         cond_q <= cond_s;
         if (rise)
            status_q <= 1'b1;
         else if (rd_hit_i && !cond_s)
            status_q <= 1'b0;
         if (rise)
            unread_q <= 1'b1;
         else if (rd_hit_i)
            unread_q <= 1'b0;
      end
   end

   assign status_o = status_q;
   assign unread_o = unread_q;

   assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> (status_q && unread_q));

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_q) |-> $past(rd_hit_i && !cond_s));

   assert_read_marks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit_i && !rise) |=> !unread_q);
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned NUM_SRC  = 20,
   parameter int unsigned NUM_REGS = 3,
   parameter int unsigned IDX_W    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [irq_status_pkg::REG_W-1:0] wdata_i,
   output logic [NUM_SRC-1:0]        mask_o
);
   import irq_status_pkg::*;

   logic [NUM_SRC-1:0] mask_q;

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_bit
      localparam int unsigned REG_IDX = s / REG_W;
      localparam int unsigned BIT_IDX = s % REG_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[s] <= 1'b1;
         else if (wr_en_i && idx_i == IDX_W'(REG_IDX))
            mask_q[s] <= wdata_i[BIT_IDX];
      end
   end

   assign mask_o = mask_q;

   assert_mask_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mask_q) |-> $past(wr_en_i));

   assert_mask_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (&mask_q));
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
   parameter int unsigned NUM_SRC  = 20,
   parameter int unsigned NUM_REGS = 3,
   parameter int unsigned IDX_W    = 2
) (
   input  irq_status_pkg::bank_e     bank_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [NUM_SRC-1:0]        status_i,
   input  logic [NUM_SRC-1:0]        mask_i,
   output logic [irq_status_pkg::REG_W-1:0] rdata_o
);
   import irq_status_pkg::*;

   localparam int unsigned PAD_W = NUM_REGS * REG_W;

   logic [PAD_W-1:0] sel_pad;

   always_comb begin
      sel_pad = '0;
      if (bank_i == BANK_MASK) sel_pad[NUM_SRC-1:0] = mask_i;
      else                     sel_pad[NUM_SRC-1:0] = status_i;
      rdata_o = '0;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (idx_i == IDX_W'(r))
            rdata_o = sel_pad[r*REG_W +: REG_W];
      end
   end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
   parameter int unsigned NUM_SRC  = 20,
   parameter bit          IN_SYNC  = 1'b0,
   localparam int unsigned NUM_REGS = irq_status_pkg::regs_for(NUM_SRC),
   localparam int unsigned IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int unsigned ADDR_W   = IDX_W + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   cond_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 rd_i,
   input  logic                 wr_i,
   input  logic [7:0]           wdata_i,
   output logic [7:0]           rdata_o,
   output logic                 irq_o
);
   import irq_status_pkg::*;

   if (NUM_SRC < 1 || NUM_SRC > 256) begin : g_bad_src
      $error("irq_status_ctrl: NUM_SRC out of range 1..256");
   end
   if (REG_W != 8) begin : g_bad_width
      $error("irq_status_ctrl: register width must be 8");
   end

   bank_e              bank;
   logic [IDX_W-1:0]   idx;
   logic [NUM_REGS-1:0] rd_hit;
   logic [NUM_SRC-1:0] status;
   logic [NUM_SRC-1:0] unread;
   logic [NUM_SRC-1:0] mask;
   logic               mask_wr;

   assign bank    = bank_e'(addr_i[ADDR_W-1]);
   assign idx     = addr_i[IDX_W-1:0];
   assign mask_wr = wr_i && (bank == BANK_MASK);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
      assign rd_hit[r] = rd_i && (bank == BANK_STATUS) && (idx == IDX_W'(r));
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      irq_src_cell #(.IN_SYNC(IN_SYNC)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .cond_i   (cond_i[s]),
         .rd_hit_i (rd_hit[s / REG_W]),
         .status_o (status[s]),
         .unread_o (unread[s])
      );
   end

   irq_mask_bank #(
      .NUM_SRC  (NUM_SRC),
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (mask_wr),
      .idx_i   (idx),
      .wdata_i (wdata_i),
      .mask_o  (mask)
   );

   irq_read_mux #(
      .NUM_SRC  (NUM_SRC),
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) u_rmux (
      .bank_i   (bank),
      .idx_i    (idx),
      .status_i (status),
      .mask_i   (mask),
      .rdata_o  (rdata_o)
   );

   assign irq_o = |(unread & ~mask);

   assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(rd_i || wr_i));
endmodule

// File: tb/irq_status_ctrl_test.sv
`timescale 1ns/1ps
module irq_status_ctrl_test;
   localparam int NS = 20;
   localparam int NR = 3;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] cond = '0;
   logic [AW-1:0] addr = '0;
   logic          rd = 1'b0;
   logic          wr = 1'b0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic          irq;

   always #2 clk = ~clk;

   irq_status_ctrl #(.NUM_SRC(NS)) uut (
      .clk(clk), .rst_n(rst_n), .cond_i(cond), .addr_i(addr),
      .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
   );

   logic [NS-1:0] m_st = '0, m_un = '0, m_mask = '1, m_pc = '0;
   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   function automatic logic [7:0] m_read(logic [AW-1:0] a);
      logic [7:0] v = '0;
      int ix = int'(a[1:0]);
      if (ix >= NR) return 8'h00;
      for (int b = 0; b < 8; b++) begin
         int s = ix * 8 + b;
         if (s < NS) v[b] = a[2] ? m_mask[s] : m_st[s];
      end
      return v;
   endfunction

   function automatic logic m_irq();
      return |(m_un & ~m_mask);
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cycle(string tag, logic [NS-1:0] c, logic r, logic w,
                        logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      cond = c; rd = r; wr = w; addr = a; wdata = d;
      #1;
      check(tag, {7'd0, irq}, {7'd0, m_irq()});
      if (r) check(tag, rdata, m_read(a));
      @(posedge clk);
      for (int s = 0; s < NS; s++) begin
         logic rise = c[s] & ~m_pc[s];
         logic hit  = r && !a[2] && (int'(a[1:0]) == s / 8);
         m_st[s] = rise | (m_st[s] & ~(hit & ~c[s]));
         m_un[s] = rise | (m_un[s] & ~hit);
         if (w && a[2] && (int'(a[1:0]) == s / 8)) m_mask[s] = d[s % 8];
      end
      m_pc = c;
   endtask

   task automatic rd_reg(string tag, logic [AW-1:0] a);
      cycle(tag, cond, 1'b1, 1'b0, a, 8'h00);
   endtask
   task automatic wr_reg(string tag, logic [AW-1:0] a, logic [7:0] d);
      cycle(tag, cond, 1'b0, 1'b1, a, d);
   endtask
   task automatic idle(string tag);
      cycle(tag, cond, 1'b0, 1'b0, '0, 8'h00);
   endtask
   task automatic drive(string tag, logic [NS-1:0] c);
      cycle(tag, c, 1'b0, 1'b0, '0, 8'h00);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         mismatched++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R2 reset values, R1 out-of-range index reads zero
      for (int a = 0; a < 8; a++) rd_reg((a == 3 || a == 7) ? "R1" : "R2", AW'(a));
      check("R2", {7'd0, irq}, 8'h00);

      // R5 masked event, R3 status set anyway
      drive("R5", NS'(1) << 3);
      idle("R5");
      rd_reg("R3", 3'd0);
      drive("R6", '0);
      idle("R6");
      rd_reg("R7", 3'd0);
      rd_reg("R7", 3'd0);

      // R11 unmask while unread, then mask again
      drive("R11", NS'(1) << 5);
      drive("R11", '0);
      wr_reg("R11", 3'd4, ~8'h20);
      idle("R11");
      wr_reg("R11", 3'd4, 8'hFF);
      idle("R11");
      wr_reg("R11", 3'd4, ~8'h20);
      idle("R11");
      rd_reg("R7", 3'd0);
      idle("R7");

      // R13 mask write and read back
      wr_reg("R13", 3'd4, 8'h00);
      wr_reg("R13", 3'd5, 8'h00);
      wr_reg("R13", 3'd6, 8'hA0);
      wr_reg("R13", 3'd6, 8'h00);
      for (int a = 4; a < 7; a++) rd_reg("R13", AW'(a));

      // R4 unmasked event raises irq
      drive("R4", NS'(1) << 9);
      idle("R4");
      drive("R6", '0);
      repeat (3) idle("R6");
      rd_reg("R6", 3'd1);
      idle("R7");
      rd_reg("R7", 3'd1);

      // R8 read while condition still high
      drive("R8", NS'(1) << 17);
      idle("R8");
      rd_reg("R8", 3'd2);
      idle("R8");
      rd_reg("R8", 3'd2);
      drive("R8", '0);
      rd_reg("R8", 3'd2);
      rd_reg("R8", 3'd2);

      // R9 irq held until all unmasked unread registers are read
      drive("R9", (NS'(1) << 0) | (NS'(1) << 12));
      drive("R9", '0);
      rd_reg("R9", 3'd0);
      idle("R9");
      rd_reg("R9", 3'd1);
      idle("R9");

      // R10 rising edge in the same cycle as the read of its register
      cycle("R10", NS'(1) << 2, 1'b1, 1'b0, 3'd0, 8'h00);
      idle("R10");
      rd_reg("R10", 3'd0);
      drive("R10", '0);
      rd_reg("R10", 3'd0);
      rd_reg("R10", 3'd0);

      // R12 status writes ignored
      drive("R12", NS'(1) << 6);
      cycle("R12", '0, 1'b0, 1'b1, 3'd0, 8'h00);
      cycle("R12", '0, 1'b0, 1'b1, 3'd2, 8'hFF);
      rd_reg("R12", 3'd0);
      rd_reg("R12", 3'd2);
      idle("R12");

      // random traffic (R1 mapping, R7/R9 behaviour over mixed patterns)
      for (int i = 0; i < 4000; i++) begin
         logic [NS-1:0] c = cond;
         logic r, w;
         logic [AW-1:0] a;
         for (int s = 0; s < NS; s++)
            if (($urandom % 16) == 0) c[s] = ~c[s];
         r = (($urandom % 4) == 0);
         w = !r && (($urandom % 10) == 0);
         a = AW'($urandom % 8);
         cycle(r ? "R7" : "R9", c, r, w, a, 8'($urandom));
      end
      for (int a = 0; a < 8; a++) rd_reg("R1", AW'(a));

      done = 1'b1;
      summary();
      $finish;
   end
endmodule